// File: doc/BRIEF.md
# Shifting Neuron Processing Grid

This block is a small two-dimensional grid of multiply-accumulate cells for convolution layers that are mapped by output-feature-map position. Each cell owns one output neuron. On every compute step a single weight is sent to all cells at once. Each cell multiplies that weight by the input neuron it receives from a neighbour and adds the product into its accumulator. Input neurons travel across the grid one cell per step. In horizontal mode a fresh column of neurons enters at the right edge and everything moves one cell to the left. In vertical mode a fresh row enters at the bottom edge and everything moves one cell up. Each cell keeps a separate register for each direction, and a select stage chooses which one feeds the multiplier and the next cell.

Two accumulation modes cover the two training passes. In local mode, used for the forward pass where kernels come input channel first, the partial sum stays in the cell until the neuron is complete. In buffer mode, used for the backward pass where kernels come output channel first, the partial sum is loaded from an external output-buffer port at the start of each kernel and handed back at the end. A post stage applies a fixed-point scale, saturation and ReLU to the accumulators and max-pools them over 2x2 windows.

Top module: `neuron_shift_grid`

## Requirements
- R1: After reset every accumulator reads zero on `psum_out_o`, and `done_o`, `psum_wr_o`, `out_vld_o`, `act_o` and `pool_o` are all zero.
- R2: On a step with `dir_i`=0, cell (r,c) takes its operand from the horizontal register of cell (r,c+1). For the right column (c=COLS-1) the operand is lane r of `edge_col_i`. The cell stores the operand in its own horizontal register, and its vertical register is left unchanged. Cell (r,c) uses lane index r*COLS+c on every flat per-cell bus, and lane i of an edge bus is bits [i*DW +: DW].
- R3: On a step with `dir_i`=1, cell (r,c) takes its operand from the vertical register of cell (r+1,c). For the bottom row (r=ROWS-1) the operand is lane c of `edge_row_i`. The cell stores the operand in its own vertical register, and its horizontal register is left unchanged.
- R4: On a step, every cell adds the product `weight_i` x operand (signed) to its accumulator in the same cycle. The result is visible on `psum_out_o` after that clock edge.
- R5: In local mode (`bwd_i`=0) the accumulator carries across steps. `clr_i` without a step zeroes every accumulator. `clr_i` together with a step leaves the product alone in the accumulator. `clr_i` takes priority over a load.
- R6: In buffer mode (`bwd_i`=1), a step with `load_i`=1 sets the accumulator to the cell's lane of `psum_in_i` plus the product. In local mode `load_i` has no effect.
- R7: A step with `last_i`=1 in buffer mode raises `psum_wr_o` for exactly the next cycle, and `psum_out_o` then holds the finished sums. The same step in local mode leaves `psum_wr_o` low.
- R8: `done_o` is high for exactly the cycle after any step with `last_i`=1, whatever the mode.
- R9: The accumulator saturates at the AW-bit signed limits, 2^(AW-1)-1 and -2^(AW-1), and does not wrap.
- R10: One cycle after `out_stb_i`, `out_vld_o` is high for one cycle. Each lane of `act_o` then holds max(0, min(2^(DW-1)-1, acc >>> FRAC)), where the shift is arithmetic. The outputs hold until the next strobe.
- R11: Together with R10, lane i*(COLS/2)+j of `pool_o` holds the maximum of the `act_o` values of cells (2i,2j), (2i,2j+1), (2i+1,2j) and (2i+1,2j+1).
- R12: In a cycle with neither a step nor a clear, no accumulator and no neuron register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Perform one shift and multiply-accumulate step |
| dir_i | input | 1 | 0 = shift left from right edge, 1 = shift up from bottom edge |
| clr_i | input | 1 | Clear accumulators |
| bwd_i | input | 1 | 0 = local accumulation, 1 = output-buffer accumulation |
| load_i | input | 1 | In buffer mode, start the kernel from `psum_in_i` |
| last_i | input | 1 | This step is the final kernel element |
| out_stb_i | input | 1 | Capture activations and pooled results |
| weight_i | input | DW | Broadcast signed weight |
| edge_col_i | input | ROWS*DW | Neurons entering the right column, one lane per row |
| edge_row_i | input | COLS*DW | Neurons entering the bottom row, one lane per column |
| psum_in_i | input | ROWS*COLS*AW | Partial sums read from the output buffer |
| psum_out_o | output | ROWS*COLS*AW | Live accumulator values, the write data for the buffer |
| psum_wr_o | output | 1 | Write strobe for `psum_out_o` in buffer mode |
| done_o | output | 1 | Pulse after the final kernel element |
| act_o | output | ROWS*COLS*DW | Scaled, saturated, ReLU outputs |
| pool_o | output | (ROWS/2)*(COLS/2)*DW | 2x2 max-pooled outputs |
| out_vld_o | output | 1 | `act_o` and `pool_o` were captured in the last cycle |

## Verification
The bench goes after the edges of the shift network. A wrong neighbour index, or a swapped edge lane, corrupts the sums of only one column or one row, so every lane is compared after every step. Turns between horizontal and vertical mode catch a design that updates both registers or selects the wrong one. In the mode tests, a load that leaks into local mode, or a write strobe raised in local mode, shows up as wrong sums or a wrong pulse. Sums pushed just past either accumulator limit expose wrap-around. In the post stage, a negative value, a value that saturates at the output width, and one that shifts to zero catch ReLU and scaling placed in the wrong order, and a pooled window that picks a neighbour's maximum.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

   // Direction in which input neurons travel through the grid
   typedef enum logic {
      DIR_HORZ = 1'b0,   // enter right column, move one cell left
      DIR_VERT = 1'b1    // enter bottom row, move one cell up
   } nsg_dir_e;

   // Where a kernel's partial sum starts from
   typedef enum logic {
      ACC_LOCAL  = 1'b0,  // keep summing in the cell
      ACC_BUFFER = 1'b1   // seed from the output buffer, hand back at the end
   } nsg_acc_e;

endpackage

// File: rtl/nsg_pe.sv
module nsg_pe
   import nsg_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic                 dir_i,
   input  logic                 clr_i,
   input  logic                 bwd_i,
   input  logic                 load_i,
   input  logic signed [DW-1:0] weight_i,
   input  logic signed [DW-1:0] h_in_i,
   input  logic signed [DW-1:0] v_in_i,
   input  logic signed [AW-1:0] psum_in_i,
   output logic signed [DW-1:0] h_q_o,
   output logic signed [DW-1:0] v_q_o,
   output logic signed [AW-1:0] acc_q_o
);

   localparam int PW  = 2 * DW;
   localparam int EXT = AW + 1 - PW;

   localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
   localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

   logic signed [DW-1:0] operand;
   logic signed [PW-1:0] product;
   logic signed [AW-1:0] base;
   logic signed [AW:0]   sum_wide;
   logic signed [AW-1:0] acc_nxt;

   // Select unit: the active direction's neighbour register feeds the multiplier
   always_comb begin
      operand = (dir_i == DIR_VERT) ? v_in_i : h_in_i;
   end

   always_comb begin
      product = weight_i * operand;
   end

   // Starting value of the accumulation for this step
   always_comb begin
      if (clr_i) begin
         base = '0;
      end else if ((bwd_i == ACC_BUFFER) && load_i) begin
         base = psum_in_i;
      end else begin
         base = acc_q_o;
      end
   end

   always_comb begin
      sum_wide = {base[AW-1], base} + {{EXT{product[PW-1]}}, product};
   end

   // Saturate on signed overflow of the extended sum
   always_comb begin
      if (sum_wide[AW] != sum_wide[AW-1]) begin
         acc_nxt = sum_wide[AW] ? ACC_MIN : ACC_MAX;
      end else begin
         acc_nxt = sum_wide[AW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q_o   <= '0;
         v_q_o   <= '0;
         acc_q_o <= '0;
      end else if (step_i) begin
         acc_q_o <= acc_nxt;
         if (dir_i == DIR_VERT) begin
            v_q_o <= v_in_i;
         end else begin
            h_q_o <= h_in_i;
         end
      end else if (clr_i) begin
         acc_q_o <= '0;
      end
   end

endmodule

// File: rtl/nsg_seq.sv
module nsg_seq
   import nsg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic last_i,
   input  logic bwd_i,
   output logic done_o,
   output logic wr_o
);

   logic kernel_end;

   always_comb begin
      kernel_end = step_i && last_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         wr_o   <= 1'b0;
      end else begin
         done_o <= kernel_end;
         wr_o   <= kernel_end && (bwd_i == ACC_BUFFER);
      end
   end

endmodule

// File: rtl/nsg_post.sv
module nsg_post #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 16,
   parameter int AW   = 40,
   parameter int FRAC = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               stb_i,
   input  logic [ROWS*COLS*AW-1:0]            acc_i,
   output logic [ROWS*COLS*DW-1:0]            act_o,
   output logic [(ROWS/2)*(COLS/2)*DW-1:0]    pool_o,
   output logic                               vld_o
);

   localparam int NPE  = ROWS * COLS;
   localparam int PR   = ROWS / 2;
   localparam int PC   = COLS / 2;
   localparam int NPL  = PR * PC;

   localparam logic signed [AW-1:0] OUT_MAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};

   logic [DW-1:0] relu_v [NPE];
   logic [DW-1:0] pool_v [NPL];

   // Scale, saturate to the output width, then ReLU
   for (genvar k = 0; k < NPE; k++) begin : g_lane
      logic signed [AW-1:0] acc_s;
      logic signed [AW-1:0] scaled;
      always_comb begin
         acc_s  = acc_i[k*AW +: AW];
         scaled = acc_s >>> FRAC;
         if (scaled < 0) begin
            relu_v[k] = '0;
         end else if (scaled > OUT_MAX) begin
            relu_v[k] = OUT_MAX[DW-1:0];
         end else begin
            relu_v[k] = scaled[DW-1:0];
         end
      end
   end

   // 2x2 max pooling over non-negative values
   for (genvar i = 0; i < PR; i++) begin : g_prow
      for (genvar j = 0; j < PC; j++) begin : g_pcol
         localparam int K0 = (2*i) * COLS + 2*j;
         logic [DW-1:0] top_m;
         logic [DW-1:0] bot_m;
         always_comb begin
            top_m = (relu_v[K0] > relu_v[K0+1]) ? relu_v[K0] : relu_v[K0+1];
            bot_m = (relu_v[K0+COLS] > relu_v[K0+COLS+1]) ?
                    relu_v[K0+COLS] : relu_v[K0+COLS+1];
            pool_v[i*PC+j] = (top_m > bot_m) ? top_m : bot_m;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
      end else begin
         vld_o <= stb_i;
      end
   end

   for (genvar k = 0; k < NPE; k++) begin : g_act_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_o[k*DW +: DW] <= '0;
         end else if (stb_i) begin
            act_o[k*DW +: DW] <= relu_v[k];
         end
      end
   end

   for (genvar p = 0; p < NPL; p++) begin : g_pool_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pool_o[p*DW +: DW] <= '0;
         end else if (stb_i) begin
            pool_o[p*DW +: DW] <= pool_v[p];
         end
      end
   end

endmodule

// File: rtl/neuron_shift_grid.sv
module neuron_shift_grid #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 16,
   parameter int AW   = 40,
   parameter int FRAC = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             step_i,
   input  logic                             dir_i,
   input  logic                             clr_i,
   input  logic                             bwd_i,
   input  logic                             load_i,
   input  logic                             last_i,
   input  logic                             out_stb_i,
   input  logic [DW-1:0]                    weight_i,
   input  logic [ROWS*DW-1:0]               edge_col_i,
   input  logic [COLS*DW-1:0]               edge_row_i,
   input  logic [ROWS*COLS*AW-1:0]          psum_in_i,
   output logic [ROWS*COLS*AW-1:0]          psum_out_o,
   output logic                             psum_wr_o,
   output logic                             done_o,
   output logic [ROWS*COLS*DW-1:0]          act_o,
   output logic [(ROWS/2)*(COLS/2)*DW-1:0]  pool_o,
   output logic                             out_vld_o
);

   localparam int NPE = ROWS * COLS;

   // Elaboration-time parameter checks
   if (ROWS < 2 || COLS < 2 || (ROWS % 2) != 0 || (COLS % 2) != 0) begin : g_bad_dim
      $error("neuron_shift_grid: ROWS and COLS must be even and at least 2");
   end
   if (AW < 2*DW + 1) begin : g_bad_aw
      $error("neuron_shift_grid: AW must be at least 2*DW+1");
   end
   if (FRAC < 0 || FRAC + DW > AW) begin : g_bad_frac
      $error("neuron_shift_grid: FRAC out of range");
   end

   logic [DW-1:0] h_q   [NPE];
   logic [DW-1:0] v_q   [NPE];
   logic [DW-1:0] h_src [NPE];
   logic [DW-1:0] v_src [NPE];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int K = r * COLS + c;

         // Horizontal source: right neighbour or the right edge
         if (c == COLS - 1) begin : g_h_edge
            assign h_src[K] = edge_col_i[r*DW +: DW];
         end else begin : g_h_nbr
            assign h_src[K] = h_q[K+1];
         end

         // Vertical source: lower neighbour or the bottom edge
         if (r == ROWS - 1) begin : g_v_edge
            assign v_src[K] = edge_row_i[c*DW +: DW];
         end else begin : g_v_nbr
            assign v_src[K] = v_q[K+COLS];
         end

         nsg_pe #(
            .DW (DW),
            .AW (AW)
         ) pe_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (step_i),
            .dir_i     (dir_i),
            .clr_i     (clr_i),
            .bwd_i     (bwd_i),
            .load_i    (load_i),
            .weight_i  (weight_i),
            .h_in_i    (h_src[K]),
            .v_in_i    (v_src[K]),
            .psum_in_i (psum_in_i[K*AW +: AW]),
            .h_q_o     (h_q[K]),
            .v_q_o     (v_q[K]),
            .acc_q_o   (psum_out_o[K*AW +: AW])
         );
      end
   end

   nsg_seq seq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .last_i (last_i),
      .bwd_i  (bwd_i),
      .done_o (done_o),
      .wr_o   (psum_wr_o)
   );

   nsg_post #(
      .ROWS (ROWS),
      .COLS (COLS),
      .DW   (DW),
      .AW   (AW),
      .FRAC (FRAC)
   ) post_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (out_stb_i),
      .acc_i  (psum_out_o),
      .act_o  (act_o),
      .pool_o (pool_o),
      .vld_o  (out_vld_o)
   );

endmodule

// File: rtl/neuron_shift_grid_chk.sv
module neuron_shift_grid_chk #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   parameter int DW   = 16,
   parameter int AW   = 40
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            step_i,
   input logic                            clr_i,
   input logic                            bwd_i,
   input logic                            last_i,
   input logic                            out_stb_i,
   input logic [ROWS*COLS*AW-1:0]         psum_out_o,
   input logic                            psum_wr_o,
   input logic                            done_o,
   input logic [ROWS*COLS*DW-1:0]         act_o,
   input logic [(ROWS/2)*(COLS/2)*DW-1:0] pool_o,
   input logic                            out_vld_o
);

   localparam int PC = COLS / 2;
   localparam int PR = ROWS / 2;

   logic past_ok;
   logic act_neg;
   logic pool_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok <= 1'b0;
      end else begin
         past_ok <= 1'b1;
      end
   end

   always_comb begin
      act_neg = 1'b0;
      for (int k = 0; k < ROWS*COLS; k++) begin
         if (act_o[k*DW + DW - 1]) act_neg = 1'b1;
      end
   end

   always_comb begin
      pool_bad = 1'b0;
      for (int i = 0; i < PR; i++) begin
         for (int j = 0; j < PC; j++) begin
            logic [DW-1:0] pv;
            logic [DW-1:0] m0, m1, m2, m3;
            int k0;
            k0 = (2*i) * COLS + 2*j;
            pv = pool_o[(i*PC+j)*DW +: DW];
            m0 = act_o[k0*DW +: DW];
            m1 = act_o[(k0+1)*DW +: DW];
            m2 = act_o[(k0+COLS)*DW +: DW];
            m3 = act_o[(k0+COLS+1)*DW +: DW];
            if (pv < m0 || pv < m1 || pv < m2 || pv < m3) pool_bad = 1'b1;
            if (pv != m0 && pv != m1 && pv != m2 && pv != m3) pool_bad = 1'b1;
         end
      end
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (done_o == $past(step_i && last_i)));

   assert_wr_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (psum_wr_o == $past(step_i && last_i && bwd_i)));

   assert_wr_implies_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      psum_wr_o |-> done_o);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(step_i) && !$past(clr_i)) |-> $stable(psum_out_o));

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_i) && !$past(step_i)) |-> (psum_out_o == '0));

   assert_vld_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_vld_o == $past(out_stb_i)));

   assert_relu_nonneg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> !act_neg);

   assert_pool_max_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> !pool_bad);

endmodule

bind neuron_shift_grid neuron_shift_grid_chk #(
   .ROWS (ROWS),
   .COLS (COLS),
   .DW   (DW),
   .AW   (AW)
) chk_i (.*);

// File: tb/neuron_shift_grid_tb_top.sv
`timescale 1ns/1ps
module neuron_shift_grid_tb_top;

   localparam int ROWS = 4;
   localparam int COLS = 4;
   localparam int DW   = 16;
   localparam int AW   = 40;
   localparam int FRAC = 8;
   localparam int NPE  = ROWS * COLS;
   localparam int NPL  = (ROWS/2) * (COLS/2);
   localparam longint ACC_MAX = (64'sd1 <<< (AW-1)) - 1;
   localparam longint ACC_MIN = -(64'sd1 <<< (AW-1));
   localparam longint OUT_MAX = (64'sd1 <<< (DW-1)) - 1;

   // Stimulus table: {clr, dir, weight[15:0], seed[15:0]}
   localparam int NV = 10;
   localparam logic [33:0] VEC [NV] = '{
      {1'b1, 1'b0, 16'h0003, 16'h000A},
      {1'b0, 1'b0, 16'hFFF9, 16'h00C8},
      {1'b0, 1'b0, 16'h0005, 16'hFF00},
      {1'b0, 1'b0, 16'h0001, 16'h04D2},
      {1'b0, 1'b1, 16'h0002, 16'h0032},
      {1'b0, 1'b1, 16'hFFFD, 16'h8000},
      {1'b0, 1'b1, 16'h7FFF, 16'h7FF0},
      {1'b0, 1'b0, 16'h8000, 16'h0100},
      {1'b1, 1'b1, 16'h0009, 16'h004D},
      {1'b0, 1'b0, 16'h0000, 16'h03E7}
   };

   logic                    clk;
   logic                    rst_n;
   logic                    step_i, dir_i, clr_i, bwd_i, load_i, last_i, out_stb_i;
   logic [DW-1:0]           weight_i;
   logic [ROWS*DW-1:0]      edge_col_i;
   logic [COLS*DW-1:0]      edge_row_i;
   logic [NPE*AW-1:0]       psum_in_i;
   logic [NPE*AW-1:0]       psum_out_o;
   logic                    psum_wr_o, done_o, out_vld_o;
   logic [NPE*DW-1:0]       act_o;
   logic [NPL*DW-1:0]       pool_o;

   neuron_shift_grid #(
      .ROWS (ROWS), .COLS (COLS), .DW (DW), .AW (AW), .FRAC (FRAC)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .step_i (step_i), .dir_i (dir_i),
      .clr_i (clr_i), .bwd_i (bwd_i), .load_i (load_i), .last_i (last_i),
      .out_stb_i (out_stb_i), .weight_i (weight_i), .edge_col_i (edge_col_i),
      .edge_row_i (edge_row_i), .psum_in_i (psum_in_i), .psum_out_o (psum_out_o),
      .psum_wr_o (psum_wr_o), .done_o (done_o), .act_o (act_o), .pool_o (pool_o),
      .out_vld_o (out_vld_o)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // Bench model of the grid
   logic signed [DW-1:0] mh [NPE];
   logic signed [DW-1:0] mv [NPE];
   longint macc [NPE];
   longint pin  [NPE];

   function automatic longint sat_acc(input longint x);
      if (x > ACC_MAX) return ACC_MAX;
      if (x < ACC_MIN) return ACC_MIN;
      return x;
   endfunction

   function automatic logic signed [DW-1:0] edge_val(input logic [15:0] seed, input int lane);
      logic [15:0] v;
      v = seed + 16'(lane * 37);
      return v;
   endfunction

   function automatic longint act_model(input longint a);
      longint s;
      s = a >>> FRAC;
      if (s < 0) return 0;
      if (s > OUT_MAX) return OUT_MAX;
      return s;
   endfunction

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_acc(input string req);
      longint got;
      bit ok;
      longint bad_got;
      longint bad_exp;
      ok = 1'b1;
      bad_got = 0;
      bad_exp = 0;
      for (int k = 0; k < NPE; k++) begin
         got = longint'($signed(psum_out_o[k*AW +: AW]));
         if (ok && got != macc[k]) begin
            ok = 1'b0;
            bad_got = got;
            bad_exp = macc[k];
         end
      end
      check(req, ok, bad_got, bad_exp);
   endtask

   task automatic idle_inputs();
      step_i = 0; dir_i = 0; clr_i = 0; bwd_i = 0; load_i = 0; last_i = 0;
      out_stb_i = 0; weight_i = '0; edge_col_i = '0; edge_row_i = '0;
   endtask

   // One step: drive at negedge, update model, return at the next negedge
   task automatic do_step(input bit d, input logic signed [DW-1:0] w, input logic [15:0] seed,
                          input bit clr, input bit bwd, input bit load, input bit last);
      logic signed [DW-1:0] oh [NPE];
      logic signed [DW-1:0] ov [NPE];
      logic signed [DW-1:0] inc;
      longint base;
      @(negedge clk);
      step_i = 1; dir_i = d; clr_i = clr; bwd_i = bwd; load_i = load; last_i = last;
      weight_i = w;
      for (int r = 0; r < ROWS; r++) edge_col_i[r*DW +: DW] = edge_val(seed, r);
      for (int c = 0; c < COLS; c++) edge_row_i[c*DW +: DW] = edge_val(seed, c);
      for (int k = 0; k < NPE; k++) psum_in_i[k*AW +: AW] = pin[k][AW-1:0];
      for (int k = 0; k < NPE; k++) begin
         oh[k] = mh[k];
         ov[k] = mv[k];
      end
      for (int k = 0; k < NPE; k++) begin
         int r;
         int c;
         r = k / COLS;
         c = k % COLS;
         if (d) inc = (r == ROWS-1) ? edge_val(seed, c) : ov[k+COLS];
         else   inc = (c == COLS-1) ? edge_val(seed, r) : oh[k+1];
         if (clr)              base = 0;
         else if (bwd && load) base = pin[k];
         else                  base = macc[k];
         macc[k] = sat_acc(base + longint'(w) * longint'(inc));
         if (d) mv[k] = inc;
         else   mh[k] = inc;
      end
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_i = 1;
      for (int k = 0; k < NPE; k++) macc[k] = 0;
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   // Watchdog: counts as a failure and still prints the summary
   initial begin
      #1000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit ok;
      idle_inputs();
      psum_in_i = '0;
      for (int k = 0; k < NPE; k++) begin
         mh[k] = '0; mv[k] = '0; macc[k] = 0; pin[k] = 0;
      end
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      ok = (psum_out_o == '0) && !done_o && !psum_wr_o && !out_vld_o &&
           (act_o == '0) && (pool_o == '0);
      check("R1 reset state", ok, longint'(ok), 1);

      // Table walk: R2 (dir 0), R3 (dir 1), R4 broadcast weight, R5 on clr rows
      for (int i = 0; i < NV; i++) begin
         logic [33:0] v;
         v = VEC[i];
         do_step(v[32], v[31:16], v[15:0], v[33], 1'b0, 1'b0, 1'b0);
         if (v[33])      check_acc("R5 clear-with-step row");
         else if (v[32]) check_acc("R3 vertical shift (R4)");
         else            check_acc("R2 horizontal shift (R4)");
      end

      // R12: idle cycles hold everything
      repeat (3) @(negedge clk);
      check_acc("R12 hold while idle");
      do_step(1'b0, 16'sd1, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check_acc("R12 neuron registers held");

      // R5: clear alone
      do_clear();
      check_acc("R5 clear without step");

      // R6: load has no effect in local mode
      for (int k = 0; k < NPE; k++) pin[k] = 64'sd123456789 + k;
      do_step(1'b0, 16'sd2, 16'd5, 1'b0, 1'b0, 1'b1, 1'b0);
      check_acc("R6 load ignored in local mode");
      check("R7 no write in local mode", !psum_wr_o, longint'(psum_wr_o), 0);

      // R6/R7/R8: buffer-mode load and final element
      for (int k = 0; k < NPE; k++) pin[k] = longint'(k) * 1000 - 7000;
      do_step(1'b1, -16'sd4, 16'd300, 1'b0, 1'b1, 1'b1, 1'b1);
      check_acc("R6 buffer load plus product");
      check("R7 write strobe after last in buffer mode", psum_wr_o, longint'(psum_wr_o), 1);
      check("R8 done after last", done_o, longint'(done_o), 1);
      @(negedge clk);
      check("R8 done is one cycle", !done_o, longint'(done_o), 0);
      check("R7 write is one cycle", !psum_wr_o, longint'(psum_wr_o), 0);

      // R8 in local mode, R7 no write
      do_step(1'b0, 16'sd1, 16'd3, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R8 done after last in local mode", done_o, longint'(done_o), 1);
      check("R7 no write after last in local mode", !psum_wr_o, longint'(psum_wr_o), 0);
      check_acc("R5 local accumulation carries");

      // R9: fill horizontal registers with positive values, then overflow both ways
      for (int s = 0; s < COLS; s++) do_step(1'b0, 16'sd0, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < NPE; k++) pin[k] = ACC_MAX - 10;
      do_step(1'b0, 16'sd1000, 16'd100, 1'b0, 1'b1, 1'b1, 1'b0);
      check_acc("R9 positive saturation");
      check("R9 lane 0 at max", longint'($signed(psum_out_o[AW-1:0])) == ACC_MAX,
            longint'($signed(psum_out_o[AW-1:0])), ACC_MAX);
      for (int k = 0; k < NPE; k++) pin[k] = ACC_MIN + 5;
      do_step(1'b0, -16'sd1000, 16'd100, 1'b0, 1'b1, 1'b1, 1'b0);
      check_acc("R9 negative saturation");

      // R10/R11: preset accumulators, then strobe the post stage
      for (int k = 0; k < NPE; k++) pin[k] = (longint'(k) * 4000 - 20000) * 256 + k * 3;
      pin[0] = -1;
      pin[5] = 64'sd50000 * 256;
      pin[10] = 255;
      do_step(1'b0, 16'sd0, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0);
      check_acc("R6 preset through load");
      @(negedge clk);
      out_stb_i = 1;
      @(posedge clk);
      @(negedge clk);
      out_stb_i = 0;
      check("R10 valid after strobe", out_vld_o, longint'(out_vld_o), 1);
      ok = 1'b1;
      for (int k = 0; k < NPE; k++) begin
         longint exp_a;
         exp_a = act_model(macc[k]);
         if (longint'(act_o[k*DW +: DW]) != exp_a) begin
            if (ok) check("R10 activation lane", 1'b0, longint'(act_o[k*DW +: DW]), exp_a);
            ok = 1'b0;
         end
      end
      if (ok) check("R10 activation lanes", 1'b1, 0, 0);
      ok = 1'b1;
      for (int i = 0; i < ROWS/2; i++) begin
         for (int j = 0; j < COLS/2; j++) begin
            longint m;
            int k0;
            k0 = 2*i*COLS + 2*j;
            m = act_model(macc[k0]);
            if (act_model(macc[k0+1]) > m)      m = act_model(macc[k0+1]);
            if (act_model(macc[k0+COLS]) > m)   m = act_model(macc[k0+COLS]);
            if (act_model(macc[k0+COLS+1]) > m) m = act_model(macc[k0+COLS+1]);
            if (longint'(pool_o[(i*(COLS/2)+j)*DW +: DW]) != m) begin
               if (ok) check("R11 pool window", 1'b0,
                             longint'(pool_o[(i*(COLS/2)+j)*DW +: DW]), m);
               ok = 1'b0;
            end
         end
      end
      if (ok) check("R11 pool windows", 1'b1, 0, 0);
      @(negedge clk);
      check("R10 valid is one cycle", !out_vld_o, longint'(out_vld_o), 0);
      check("R10 activations held", longint'(act_o[5*DW +: DW]) == OUT_MAX,
            longint'(act_o[5*DW +: DW]), OUT_MAX);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule